// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns a 32-bit virtual address into a physical address for a processor core. A fully associative array of translation entries is searched in parallel. Each entry holds a virtual page, an address-space tag, a physical page and a few attribute bits. Because every entry carries its own address-space tag, translations from many processes can sit in the array together, and a context switch only needs to change the current tag. It does not need a flush. The 12-bit page offset is never translated.

The three most significant address bits also select a region. The user region and the upper kernel region are translated through the array. Two kernel windows bypass translation and map straight onto the low part of physical space: one is cached and one is uncached. A lookup in a translated region that finds no entry raises a miss fault, and software handles it. There is no hardware walk of the page tables. A store to an entry marked read-only raises a protection fault.

Software fills the array by writing a whole entry at a replacement index it chooses. It removes a stale translation by invalidating the entry at a given index. The result of a lookup appears in the same cycle as the lookup. Writes, invalidations and the referenced-bit update take effect at the next clock edge.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup in a translated region reports a miss.
- R2: A lookup hits only when an entry is valid and both its virtual page number (`lk_va[31:12]`) and its tag equal `cur_asid`. A lookup in a translated region with no matching entry asserts `xl_miss` and leaves `xl_hit` low.
- R3: `xl_pa[11:0]` always equals `lk_va[11:0]`. On a hit `xl_pa[31:12]` is the entry's physical page. On a miss it is zero.
- R4: Addresses with `lk_va[31]`=0 (user) and with `lk_va[31:30]`=11 (kernel mapped) are translated through the entry array.
- R5: Addresses with `lk_va[31:29]`=100 are not translated. In that case `xl_pa` = {000, `lk_va[28:0]`}, `xl_cached`=1, and no hit, miss or protection flag is raised, for loads and stores alike.
- R6: Addresses with `lk_va[31:29]`=101 give the same direct address as R5, with `xl_cached`=0.
- R7: In a translated region, `xl_cached` equals the matching entry's cacheable bit on a hit and is 0 on a miss.
- R8: A store (`lk_store`=1) that hits an entry whose write-permission bit is 0 asserts `xl_prot` together with `xl_hit`. Loads and stores to writable entries never assert `xl_prot`.
- R9: Writing an entry clears its referenced bit. Every hit sets the referenced bit from the next cycle on. `xl_ref` and `xl_dirty` report the hit entry's bits as they stood before the current cycle's update, and both are 0 when there is no hit.
- R10: A write replaces every field of the entry at `wr_idx` from the next cycle on, and the previous translation at that index no longer hits.
- R11: An invalidate clears the valid bit of the entry at `inv_idx` from the next cycle on. When a write and an invalidate target the same index in one cycle, the write wins. When they target different indices, both take effect.
- R12: With `lk_valid`=0, `xl_hit`, `xl_miss`, `xl_prot`, `xl_cached`, `xl_ref` and `xl_dirty` are all 0.
- R13: Entries with the same virtual page and different tags coexist, and `cur_asid` alone selects which one translates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_store | input | 1 | Lookup is a store (1) or load (0) |
| lk_va | input | 32 | Virtual address to translate |
| cur_asid | input | 6 | Current address-space tag |
| wr_en | input | 1 | Write a whole entry |
| wr_idx | input | 6 | Replacement index for the write |
| wr_vpn | input | 20 | Virtual page of the new entry |
| wr_asid | input | 6 | Tag of the new entry |
| wr_ppn | input | 20 | Physical page of the new entry |
| wr_valid | input | 1 | Valid bit of the new entry |
| wr_rw | input | 1 | 1 = read/write, 0 = read-only |
| wr_dirty | input | 1 | Dirty bit of the new entry |
| wr_cached | input | 1 | Cacheable bit of the new entry |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | 6 | Index to invalidate |
| xl_pa | output | 32 | Physical address |
| xl_hit | output | 1 | Translation hit |
| xl_miss | output | 1 | Miss fault in a translated region |
| xl_prot | output | 1 | Protection fault (store to read-only) |
| xl_cached | output | 1 | Access is cacheable |
| xl_ref | output | 1 | Referenced bit of the hit entry |
| xl_dirty | output | 1 | Dirty bit of the hit entry |

## Verification
Lookups are run against entries that share a virtual page but differ in tag, against entries that share a tag but differ in page, and after overwrites and invalidations. This separates a comparator that ignores the tag from one that ignores the page, and stale state from fresh state. Both unmapped kernel windows are tried with loads and stores and with a live entry present. This shows that the window decode bypasses the array and that the two windows differ only in cacheability. Repeated hits to one entry show the referenced bit moving from 0 to 1. Simultaneous write and invalidate, on the same index and on different indices, pin down which of the two takes priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    RG_USER    = 2'd0,
    RG_KDIRECT = 2'd1,
    RG_KUNCACH = 2'd2,
    RG_KMAPPED = 2'd3
  } region_e;

  function automatic region_e classify(input logic [2:0] top);
    if (!top[2])             return RG_USER;
    else if (top[1])         return RG_KMAPPED;
    else if (top[0])         return RG_KUNCACH;
    else                     return RG_KDIRECT;
  endfunction
endpackage

// File: rtl/tlb_region.sv
module tlb_region
  import tlb_pkg::*;
(
  input  logic [2:0] top_bits,
  output logic       mapped,
  output logic       win_cached
);
  region_e rg;
  always_comb begin
    rg         = classify(top_bits);
    mapped     = (rg == RG_USER) || (rg == RG_KMAPPED);
    win_cached = (rg == RG_KDIRECT);
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             e_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_valid[g] && (e_vpn[g] == key_vpn) && (e_asid[g] == key_asid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
    any_hit = |match;
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [ASID_W-1:0]              wr_asid,
  input  logic [PPN_W-1:0]               wr_ppn,
  input  logic                           wr_valid,
  input  logic                           wr_rw,
  input  logic                           wr_dirty,
  input  logic                           wr_cached,
  input  logic                           inv_en,
  input  logic [IDX_W-1:0]               inv_idx,
  input  logic                           hit_en,
  input  logic [IDX_W-1:0]               hit_idx,
  output logic [ENTRIES-1:0]             e_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn,
  output logic [ENTRIES-1:0][ASID_W-1:0] e_asid,
  output logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn,
  output logic [ENTRIES-1:0]             e_rw,
  output logic [ENTRIES-1:0]             e_dirty,
  output logic [ENTRIES-1:0]             e_cached,
  output logic [ENTRIES-1:0]             e_ref
);
  logic [ENTRIES-1:0]             n_valid, n_rw, n_dirty, n_cached, n_ref;
  logic [ENTRIES-1:0][VPN_W-1:0]  n_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] n_asid;
  logic [ENTRIES-1:0][PPN_W-1:0]  n_ppn;
  logic                           upd_en;

  always_comb begin
    n_valid = e_valid;  n_rw  = e_rw;   n_dirty = e_dirty; n_cached = e_cached;
    n_ref   = e_ref;    n_vpn = e_vpn;  n_asid  = e_asid;  n_ppn    = e_ppn;
    upd_en  = wr_en || inv_en || hit_en;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_en && hit_idx == IDX_W'(i)) n_ref[i]   = 1'b1;
      if (inv_en && inv_idx == IDX_W'(i)) n_valid[i] = 1'b0;
      if (wr_en && wr_idx == IDX_W'(i)) begin
        n_valid[i]  = wr_valid;
        n_vpn[i]    = wr_vpn;
        n_asid[i]   = wr_asid;
        n_ppn[i]    = wr_ppn;
        n_rw[i]     = wr_rw;
        n_dirty[i]  = wr_dirty;
        n_cached[i] = wr_cached;
        n_ref[i]    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0; e_rw  <= '0; e_dirty <= '0; e_cached <= '0;
      e_ref   <= '0; e_vpn <= '0; e_asid  <= '0; e_ppn    <= '0;
    end else if (upd_en) begin
      e_valid <= n_valid; e_rw  <= n_rw;  e_dirty <= n_dirty; e_cached <= n_cached;
      e_ref   <= n_ref;   e_vpn <= n_vpn; e_asid  <= n_asid;  e_ppn    <= n_ppn;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_store,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_valid,
  input  logic              wr_rw,
  input  logic              wr_dirty,
  input  logic              wr_cached,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  output logic [PA_W-1:0]   xl_pa,
  output logic              xl_hit,
  output logic              xl_miss,
  output logic              xl_prot,
  output logic              xl_cached,
  output logic              xl_ref,
  output logic              xl_dirty
);
  logic [ENTRIES-1:0]             e_valid, e_rw, e_dirty, e_cached, e_ref;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
  logic                           any_hit, mapped, win_cached, tr_hit;
  logic [IDX_W-1:0]               hit_idx;

  tlb_region u_region (
    .top_bits   (lk_va[VA_W-1 -: 3]),
    .mapped     (mapped),
    .win_cached (win_cached)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .e_valid (e_valid), .e_vpn (e_vpn), .e_asid (e_asid),
    .key_vpn (lk_va[VA_W-1:OFF_W]), .key_asid (cur_asid),
    .any_hit (any_hit), .hit_idx (hit_idx)
  );

  tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_store (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_vpn (wr_vpn), .wr_asid (wr_asid),
    .wr_ppn (wr_ppn), .wr_valid (wr_valid), .wr_rw (wr_rw), .wr_dirty (wr_dirty),
    .wr_cached (wr_cached), .inv_en (inv_en), .inv_idx (inv_idx),
    .hit_en (tr_hit), .hit_idx (hit_idx),
    .e_valid (e_valid), .e_vpn (e_vpn), .e_asid (e_asid), .e_ppn (e_ppn),
    .e_rw (e_rw), .e_dirty (e_dirty), .e_cached (e_cached), .e_ref (e_ref)
  );

  always_comb begin
    tr_hit    = lk_valid && mapped && any_hit;
    xl_hit    = tr_hit;
    xl_miss   = lk_valid && mapped && !any_hit;
    xl_prot   = tr_hit && lk_store && !e_rw[hit_idx];
    xl_ref    = tr_hit && e_ref[hit_idx];
    xl_dirty  = tr_hit && e_dirty[hit_idx];
    xl_cached = lk_valid && (mapped ? (tr_hit && e_cached[hit_idx]) : win_cached);
    if (lk_valid && !mapped)
      xl_pa = PA_W'(lk_va[VA_W-4:0]);
    else if (tr_hit)
      xl_pa = {e_ppn[hit_idx], lk_va[OFF_W-1:0]};
    else
      xl_pa = {{PPN_W{1'b0}}, lk_va[OFF_W-1:0]};
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ASID_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_store,
  input logic [VA_W-1:0]   lk_va,
  input logic [ASID_W-1:0] cur_asid,
  input logic              wr_en,
  input logic              inv_en,
  input logic [PA_W-1:0]   xl_pa,
  input logic              xl_hit,
  input logic              xl_miss,
  input logic              xl_prot,
  input logic              xl_cached,
  input logic              xl_ref
);
  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_hit && xl_miss));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (xl_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

  p_kdirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_va[VA_W-1 -: 3] == 3'b100) |->
      (!xl_hit && !xl_miss && !xl_prot && xl_cached && xl_pa == PA_W'(lk_va[VA_W-4:0])));

  p_kuncached_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_va[VA_W-1 -: 3] == 3'b101) |->
      (!xl_hit && !xl_miss && !xl_prot && !xl_cached && xl_pa == PA_W'(lk_va[VA_W-4:0])));

  p_prot_store_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_prot |-> (xl_hit && lk_store));

  p_ref_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && $past(xl_hit) && lk_va == $past(lk_va) && cur_asid == $past(cur_asid)
     && !$past(wr_en) && !$past(inv_en)) |-> xl_ref);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!xl_hit && !xl_miss && !xl_prot && !xl_cached));
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        lk_valid, lk_store;
  logic [31:0] lk_va;
  logic [5:0]  cur_asid;
  logic        wr_en, wr_valid, wr_rw, wr_dirty, wr_cached, inv_en;
  logic [5:0]  wr_idx, wr_asid, inv_idx;
  logic [19:0] wr_vpn, wr_ppn;
  logic [31:0] xl_pa;
  logic        xl_hit, xl_miss, xl_prot, xl_cached, xl_ref, xl_dirty;

  asid_tlb u_dut (.*);

  typedef struct {
    logic [31:0] pa;
    logic hit, miss, prot, cached, rf, dirty;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model of the entry array
  logic        m_v[64], m_rw[64], m_d[64], m_c[64], m_ref[64];
  logic [19:0] m_vpn[64], m_ppn[64];
  logic [5:0]  m_asid[64];

  int checks = 0, errors = 0;
  bit done = 0;

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic idle_inputs();
    lk_valid = 0; lk_store = 0; lk_va = '0; cur_asid = '0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_ppn = '0;
    wr_valid = 0; wr_rw = 0; wr_dirty = 0; wr_cached = 0;
    inv_en = 0; inv_idx = '0;
  endtask

  task automatic model_write(int i, logic [19:0] vpn, logic [5:0] asid, logic [19:0] ppn,
                             logic v, logic rw, logic d, logic c);
    m_v[i] = v; m_vpn[i] = vpn; m_asid[i] = asid; m_ppn[i] = ppn;
    m_rw[i] = rw; m_d[i] = d; m_c[i] = c; m_ref[i] = 0;
  endtask

  task automatic drive_write(int i, logic [19:0] vpn, logic [5:0] asid, logic [19:0] ppn,
                             logic v, logic rw, logic d, logic c);
    wr_en = 1; wr_idx = 6'(i); wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
    wr_valid = v; wr_rw = rw; wr_dirty = d; wr_cached = c;
  endtask

  task automatic do_write(int i, logic [19:0] vpn, logic [5:0] asid, logic [19:0] ppn,
                          logic v, logic rw, logic d, logic c);
    @(negedge clk); idle_inputs();
    drive_write(i, vpn, asid, ppn, v, rw, d, c);
    model_write(i, vpn, asid, ppn, v, rw, d, c);
  endtask

  task automatic do_inv(int i);
    @(negedge clk); idle_inputs();
    inv_en = 1; inv_idx = 6'(i);
    m_v[i] = 0;
  endtask

  // write and invalidate in one cycle; the write takes priority (R11)
  task automatic do_wr_inv(int wi, int ii, logic [19:0] vpn, logic [5:0] asid, logic [19:0] ppn);
    @(negedge clk); idle_inputs();
    drive_write(wi, vpn, asid, ppn, 1, 1, 0, 1);
    inv_en = 1; inv_idx = 6'(ii);
    m_v[ii] = 0;
    model_write(wi, vpn, asid, ppn, 1, 1, 0, 1);
  endtask

  task automatic do_look(logic [31:0] va, logic st, logic [5:0] asid, string tag);
    exp_t e;
    int   hi;
    hi = -1;
    @(negedge clk); idle_inputs();
    lk_valid = 1; lk_store = st; lk_va = va; cur_asid = asid;
    e.tag = tag; e.hit = 0; e.miss = 0; e.prot = 0; e.cached = 0; e.rf = 0; e.dirty = 0;
    if (va[31:29] == 3'b100 || va[31:29] == 3'b101) begin
      e.pa = {3'b000, va[28:0]};
      e.cached = (va[31:29] == 3'b100);
    end else begin
      for (int i = 0; i < 64; i++)
        if (m_v[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) hi = i;
      if (hi >= 0) begin
        e.hit = 1; e.pa = {m_ppn[hi], va[11:0]}; e.prot = st && !m_rw[hi];
        e.cached = m_c[hi]; e.rf = m_ref[hi]; e.dirty = m_d[hi];
        m_ref[hi] = 1;
      end else begin
        e.miss = 1; e.pa = {20'h0, va[11:0]};
      end
    end
    exp_q.push_back(e);
  endtask

  // Monitor: compares each lookup a quarter period after it is driven
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && lk_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: lookup with no expected item (va=%h)", lk_va);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (xl_pa !== e.pa || xl_hit !== e.hit || xl_miss !== e.miss || xl_prot !== e.prot ||
              xl_cached !== e.cached || xl_ref !== e.rf || xl_dirty !== e.dirty) begin
            errors++;
            $display("FAIL %s: got pa=%h h=%b m=%b p=%b c=%b r=%b d=%b exp pa=%h h=%b m=%b p=%b c=%b r=%b d=%b",
                     e.tag, xl_pa, xl_hit, xl_miss, xl_prot, xl_cached, xl_ref, xl_dirty,
                     e.pa, e.hit, e.miss, e.prot, e.cached, e.rf, e.dirty);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) model_write(i, '0, '0, '0, 0, 0, 0, 0);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: no lookup, no flags even with a mapped address present
    @(negedge clk); idle_inputs(); lk_va = 32'h0040_0abc;
    #(CLK_P/4);
    checks++;
    if ({xl_hit, xl_miss, xl_prot, xl_cached, xl_ref, xl_dirty} !== 6'b0) begin
      errors++;
      $display("FAIL R12: flags=%b exp=000000",
               {xl_hit, xl_miss, xl_prot, xl_cached, xl_ref, xl_dirty});
    end

    do_look(32'h0040_0123, 0, 6'd0, "R1 miss after reset");
    do_look(32'hC000_1000, 0, 6'd0, "R1 kernel mapped miss after reset");

    do_write(0, 20'h00400, 6'd5, 20'h12345, 1, 0, 0, 1);
    do_look(32'h0040_0abc, 0, 6'd5, "R2 R3 R7 R9 first hit ref=0");
    do_look(32'h0040_0abc, 0, 6'd5, "R9 second hit ref=1");
    do_look(32'h0040_0abc, 1, 6'd5, "R8 store to read-only");
    do_look(32'h0040_0abc, 0, 6'd6, "R2 R13 other tag misses");
    do_look(32'h0040_1abc, 0, 6'd5, "R2 other page misses");

    do_write(1, 20'h00400, 6'd6, 20'h0aaaa, 1, 1, 1, 0);
    do_look(32'h0040_0fff, 1, 6'd6, "R13 R8 R7 writable uncached dirty");
    do_look(32'h0040_0000, 0, 6'd5, "R13 original tag still maps");

    do_write(63, 20'hE0001, 6'd2, 20'h00777, 1, 1, 0, 1);
    do_look(32'hE000_1010, 0, 6'd2, "R4 kernel mapped hit");
    do_look(32'hE000_2010, 0, 6'd2, "R4 kernel mapped miss");
    do_look(32'h8123_4567, 0, 6'd2, "R5 cached window load");
    do_look(32'h8040_0abc, 1, 6'd5, "R5 cached window store");
    do_look(32'hA765_4321, 0, 6'd5, "R6 uncached window load");
    do_look(32'hBFFF_FFFF, 1, 6'd0, "R6 uncached window store");

    do_write(0, 20'h00500, 6'd5, 20'h00001, 1, 1, 0, 1);
    do_look(32'h0040_0abc, 0, 6'd5, "R10 old translation gone");
    do_look(32'h0050_0abc, 0, 6'd5, "R10 new translation ref cleared");

    do_inv(1);
    do_look(32'h0040_0abc, 0, 6'd6, "R11 invalidated entry misses");

    do_wr_inv(63, 63, 20'h00600, 6'd2, 20'h0beef);
    do_look(32'h0060_0123, 0, 6'd2, "R11 write beats invalidate");
    do_look(32'hE000_1010, 0, 6'd2, "R10 R11 overwritten kernel entry");

    do_wr_inv(2, 0, 20'h00700, 6'd7, 20'h0cafe);
    do_look(32'h0070_0555, 0, 6'd7, "R11 write with other-index invalidate");
    do_look(32'h0050_0abc, 0, 6'd5, "R11 other-index invalidate applied");

    do_look(32'h0070_0555, 1, 6'd7, "R8 store to writable entry");

    @(negedge clk); idle_inputs();
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expected items left, exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule